// File: doc/BRIEF.md
# Quad-lane byte SAD accumulator

This datapath block builds up the sum of absolute differences between two blocks of 8-bit pixels, four pixel pairs per clock. Each cycle it receives one 64-bit word per image. A 2-bit offset per image picks four adjacent bytes out of that word, so pixel rows that do not start on a word boundary are used as they are, with no separate realignment step. Each of the four lanes forms the unsigned absolute difference of its two bytes and adds it to that lane's own 16-bit running sum.

A caller clears the sums, then asserts the enable once for each group of four pixel pairs in the block. It then reads the four partial sums, or their 18-bit total. With 16-bit lane sums, a block of up to 32x32 pixels fits without wrap. Typical use is 8x8 or 16x16. If a lane does wrap, a sticky flag records it.

Top module: `quad_sad_acc`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all four lane sums, all four overflow flags and the total read zero.
- R2: An offset k on `a_off_i` takes bytes k, k+1, k+2 and k+3 of `a_word_i` (byte 0 is bits 7:0) as the first operands of lanes 0, 1, 2 and 3 in that order.
- R3: `b_off_i` selects bytes of `b_word_i` in the same way, independently of `a_off_i`.
- R4: Each lane adds |a - b|, with a and b treated as unsigned 8-bit values, to its own sum. Lane 0 is read on `acc_o[15:0]`, lane 1 on `acc_o[31:16]`, lane 2 on `acc_o[47:32]` and lane 3 on `acc_o[63:48]`.
- R5: A cycle with `en_i` high and `clr_i` low shows its result on the outputs one clock later. Enabled cycles may follow one another every clock, and each one is counted.
- R6: A cycle with `en_i` and `clr_i` both low leaves every lane sum and flag unchanged, whatever the data and offset inputs carry.
- R7: A cycle with `clr_i` high zeroes all lane sums and overflow flags at the next clock. It takes priority over `en_i`.
- R8: A lane sum wraps modulo 65536. Bit i of `ovf_o` is set when lane i carries out of bit 15, and it stays set until a clear or a reset.
- R9: `sum_o` equals the sum of the four lane sums, zero-extended to 18 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all sums and flags |
| en_i | input | 1 | Accumulate this cycle |
| a_word_i | input | 64 | First image source word |
| b_word_i | input | 64 | Second image source word |
| a_off_i | input | 2 | Byte offset into `a_word_i` |
| b_off_i | input | 2 | Byte offset into `b_word_i` |
| acc_o | output | 64 | Four 16-bit lane sums, lane 0 in the low bits |
| ovf_o | output | 4 | Sticky wrap flag per lane |
| sum_o | output | 18 | Total of the four lane sums |

## Verification
The embedded assertions assume that `clr_i`, `en_i` and both offsets carry defined values once reset is released. They also assume that `clr_i` alone decides clearing, whatever the data inputs hold. The stimulus drives every input from time zero and changes it only on the falling clock edge, so these values are settled at each rising edge. The random phase keeps clears rare and lets the lane sums run long enough to cross the wrap point, so the sticky flag is tested against the bench model. A directed run then fills every lane to exactly 65535 and pushes it one step further.

// File: rtl/sad_pkg.sv
package sad_pkg;

    typedef enum logic [1:0] {
        LANE_HOLD  = 2'd0,
        LANE_CLEAR = 2'd1,
        LANE_ADD   = 2'd2
    } lane_op_e;

    // Clear wins over enable; otherwise accumulate when enabled.
    function automatic lane_op_e pick_op(input logic clr, input logic en);
        if (clr)
            return LANE_CLEAR;
        else if (en)
            return LANE_ADD;
        else
            return LANE_HOLD;
    endfunction

endpackage

// File: rtl/sad_byte_funnel.sv
module sad_byte_funnel #(
    parameter int SRC_W = 64,
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [SRC_W-1:0]       word_i,
    input  logic [OFF_W-1:0]       off_i,
    output logic [LANES*PIX_W-1:0] pix_o
);
    localparam int OUT_W  = LANES * PIX_W;
    localparam int SH_W   = $clog2(SRC_W) + 1;

    logic [SRC_W-1:0] shifted_w;
    logic [SH_W-1:0]  shamt_w;

    always_comb begin
        shamt_w   = SH_W'(off_i) * SH_W'(PIX_W);
        shifted_w = word_i >> shamt_w;
        pix_o     = shifted_w[OUT_W-1:0];
    end

    // Offset zero must pass the low bytes straight through.
    always_comb begin
        if (off_i == '0)
            AST_FUNNEL_ZERO_OFF: assert (pix_o == word_i[OUT_W-1:0]); // R2
    end

endmodule

// File: rtl/sad_abs_diff.sv
module sad_abs_diff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    output logic [PIX_W-1:0] d_o
);
    always_comb begin
        if (a_i >= b_i)
            d_o = a_i - b_i;
        else
            d_o = b_i - a_i;
    end

    // A zero difference appears exactly when the two pixels match.
    always_comb begin
        AST_DIFF_ZERO_IFF_EQUAL: assert ((d_o == '0) == (a_i == b_i)); // R4
    end

endmodule

// File: rtl/sad_lane_acc.sv
module sad_lane_acc
    import sad_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lane_op_e         op_i,
    input  logic [PIX_W-1:0] diff_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } lane_state_t;

    lane_state_t    st_d, st_q;
    logic [ACC_W:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.acc} + (ACC_W+1)'(diff_i);
        unique case (op_i)
            LANE_CLEAR: begin
                st_d.acc = '0;
                st_d.ovf = 1'b0;
            end
            LANE_ADD: begin
                st_d.acc = sum_d[ACC_W-1:0];
                st_d.ovf = st_q.ovf | sum_d[ACC_W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_o = st_q.acc;
    assign ovf_o = st_q.ovf;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == LANE_HOLD |=> $stable(st_q)); // R6

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == LANE_CLEAR |=> (acc_o == '0 && !ovf_o)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && op_i != LANE_CLEAR) |=> ovf_o); // R8

    AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == LANE_ADD |=> acc_o == ACC_W'($past(acc_o) + ACC_W'($past(diff_i)))); // R5

endmodule

// File: rtl/quad_sad_acc.sv
module quad_sad_acc
    import sad_pkg::*;
#(
    parameter int SRC_W = 64,
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int ACC_W = 16,
    parameter int OFF_W = 2,
    localparam int SUM_W = ACC_W + $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   en_i,
    input  logic [SRC_W-1:0]       a_word_i,
    input  logic [SRC_W-1:0]       b_word_i,
    input  logic [OFF_W-1:0]       a_off_i,
    input  logic [OFF_W-1:0]       b_off_i,
    output logic [LANES*ACC_W-1:0] acc_o,
    output logic [LANES-1:0]       ovf_o,
    output logic [SUM_W-1:0]       sum_o
);
    localparam int PIX_BUS = LANES * PIX_W;

    logic [PIX_BUS-1:0] a_pix_w, b_pix_w;
    lane_op_e           op_w;

    assign op_w = pick_op(clr_i, en_i);

    sad_byte_funnel #(
        .SRC_W(SRC_W), .PIX_W(PIX_W), .LANES(LANES), .OFF_W(OFF_W)
    ) u_funnel_a (
        .word_i(a_word_i), .off_i(a_off_i), .pix_o(a_pix_w)
    );

    sad_byte_funnel #(
        .SRC_W(SRC_W), .PIX_W(PIX_W), .LANES(LANES), .OFF_W(OFF_W)
    ) u_funnel_b (
        .word_i(b_word_i), .off_i(b_off_i), .pix_o(b_pix_w)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PIX_W-1:0] diff_w;

        sad_abs_diff #(.PIX_W(PIX_W)) u_diff (
            .a_i(a_pix_w[g*PIX_W +: PIX_W]),
            .b_i(b_pix_w[g*PIX_W +: PIX_W]),
            .d_o(diff_w)
        );

        sad_lane_acc #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .op_i  (op_w),
            .diff_i(diff_w),
            .acc_o (acc_o[g*ACC_W +: ACC_W]),
            .ovf_o (ovf_o[g])
        );
    end

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < LANES; i++)
            sum_o = sum_o + SUM_W'(acc_o[i*ACC_W +: ACC_W]);
    end

    AST_TOTAL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o >= SUM_W'(acc_o[ACC_W-1:0])); // R9

    AST_CLEAR_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sum_o == '0 && ovf_o == '0)); // R7

endmodule

// File: tb/quad_sad_acc_test.sv
module quad_sad_acc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b0;
    logic        en_i = 1'b0;
    logic [63:0] a_word_i = '0;
    logic [63:0] b_word_i = '0;
    logic [1:0]  a_off_i = '0;
    logic [1:0]  b_off_i = '0;
    logic [63:0] acc_o;
    logic [3:0]  ovf_o;
    logic [17:0] sum_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_acc [4];
    logic [3:0]  m_ovf;

    always #4 clk = ~clk;

    quad_sad_acc uut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .en_i(en_i),
        .a_word_i(a_word_i), .b_word_i(b_word_i),
        .a_off_i(a_off_i), .b_off_i(b_off_i),
        .acc_o(acc_o), .ovf_o(ovf_o), .sum_o(sum_o)
    );

    function automatic logic [7:0] pick_byte(logic [63:0] w, int off, int lane);
        return w[(off+lane)*8 +: 8];
    endfunction

    function automatic logic [7:0] absd(logic [7:0] a, logic [7:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        logic [63:0] e_acc;
        logic [17:0] e_sum;
        e_sum = '0;
        for (int i = 0; i < 4; i++) begin
            e_acc[i*16 +: 16] = m_acc[i];
            e_sum = e_sum + 18'(m_acc[i]);
        end
        check(tag, acc_o, e_acc);
        check({tag, " R8 flags"}, 64'(ovf_o), 64'(m_ovf));
        check({tag, " R9 total"}, 64'(sum_o), 64'(e_sum));
    endtask

    // Called at a falling edge: drive, update model, cross one rising edge.
    task automatic step(logic [63:0] a, logic [63:0] b, int oa, int ob,
                        logic e, logic c, string tag);
        logic [16:0] s;
        a_word_i = a; b_word_i = b;
        a_off_i = 2'(oa); b_off_i = 2'(ob);
        en_i = e; clr_i = c;
        if (c) begin
            for (int i = 0; i < 4; i++) m_acc[i] = '0;
            m_ovf = '0;
        end else if (e) begin
            for (int i = 0; i < 4; i++) begin
                s = 17'(m_acc[i]) + 17'(absd(pick_byte(a, oa, i), pick_byte(b, ob, i)));
                if (s[16]) m_ovf[i] = 1'b1;
                m_acc[i] = s[15:0];
            end
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_ovf = '0;
        repeat (3) @(negedge clk);
        compare_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after reset");

        // R2: each A offset against a zero B word, so lane i reads byte k+i
        for (int k = 0; k < 4; k++) begin
            step(64'h8877_6655_4433_2211, 64'h0, k, 0, 1'b1, 1'b0, "R2 a offset");
            step('0, '0, 0, 0, 1'b0, 1'b1, "R7 clear");
        end
        // R3: B offsets independent of A offset
        for (int k = 0; k < 4; k++) begin
            step(64'h0, 64'hF0E0_D0C0_B0A0_9080, 3 - k, k, 1'b1, 1'b0, "R3 b offset");
            step('0, '0, 0, 0, 1'b0, 1'b1, "R7 clear");
        end
        // R4: unsigned magnitude both directions per lane
        step(64'h0000_0000_00FF_01FE, 64'h0000_0000_FF00_FE01, 0, 0, 1'b1, 1'b0, "R4 abs both ways");
        // R6: idle cycles with busy data leave state
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, 2, 1'b0, 1'b0, "R6 idle hold");
        step(64'h1234_5678_9ABC_DEF0, 64'h0, 3, 0, 1'b0, 1'b0, "R6 idle hold");
        // R7: clear beats enable
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 0, 1'b1, 1'b1, "R7 clear over enable");
        // R5: back-to-back enabled cycles
        for (int n = 0; n < 6; n++)
            step({$urandom, $urandom}, {$urandom, $urandom}, n % 4, (n+1) % 4,
                 1'b1, 1'b0, "R5 back to back");
        step('0, '0, 0, 0, 1'b0, 1'b1, "R7 clear");
        // R8: 257 * 255 = 65535 exactly, one more wraps every lane
        for (int n = 0; n < 257; n++)
            step(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 0, 1'b1, 1'b0, "R8 fill");
        step(64'h0000_0000_0201_0302, 64'h0, 0, 0, 1'b1, 1'b0, "R8 wrap");
        step(64'h0, 64'h0505_0505_0505_0505, 0, 0, 1'b1, 1'b0, "R8 sticky");
        step('0, '0, 0, 0, 1'b0, 1'b1, "R8 flags clear");
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic e, c;
            e = ($urandom % 8) != 0;
            c = ($urandom % 400) == 0;
            step({$urandom, $urandom}, {$urandom, $urandom},
                 int'($urandom % 4), int'($urandom % 4), e, c, "R4 random");
        end
        finish_run();
    end

endmodule